// File: doc/BRIEF.md
# GPIO External Interrupt Router

This block connects a set of synchronous GPIO ports to sixteen external interrupt lines. Each line picks a source port and a pin from the four-pin group that belongs to it. It watches that pin for the edges it has been told to respond to and holds a sticky pending flag. Software sets up the lines through a small write-only register port. Pending flags are cleared by writing ones to a clear register. The flags are always visible on an output vector. A single interrupt output is asserted whenever an enabled line has a pending flag.

Each line is a two-state machine. `LN_IDLE` is the state with no flag pending, and `LN_PEND` is the state with the flag pending. The transition *arm* (LN_IDLE to LN_PEND) is taken when an enabled edge is detected. The transition *release* (LN_PEND to LN_IDLE) is taken when a clear bit for the line is written and no enabled edge arrives in the same cycle. In every other case the line stays in its current state. When a line's source selection changes, edge detection is suppressed for one cycle. During that cycle the stored previous value is reloaded from the new source.

Top module: `exti_router`

## Requirements
- R1: After the asynchronous active-low reset, every select and enable field is zero, `flags_o` is zero and `irq_o` is 0. Pin activity does not set any flag until an edge enable is written.
- R2: When bit n of the rising-enable register (address 3) is set, a 0-to-1 change on line n's selected pin sets flag n. The flag appears at the clock edge that first samples the new pin value.
- R3: Bit n of the falling-enable register (address 4) does the same for a 1-to-0 change. With both bits set, either edge sets the flag.
- R4: An edge whose polarity is not enabled for line n leaves flag n clear.
- R5: Address 0 holds port selects for lines 0-7 and address 1 holds them for lines 8-15. Each line has a 4-bit field at bits [4k+3:4k] with k = n mod 8, and the port number sits in the low bits of that field. Pin k of port p is bit 16p+k of `pins_i`.
- R6: Address 2 bits [2n+1:2n] select a pin within line n's group. The effective pin is 4*(n/4) + sel. Pins outside the selected one never affect line n.
- R7: Writing address 6 clears every flag n whose data bit n is 1. Data bits that are 0 have no effect.
- R8: If an enabled edge on line n and a clear of bit n fall in the same cycle, flag n ends up set.
- R9: Flags are set whatever the interrupt-enable register (address 5) holds. `irq_o` is the OR over n of flag[n] AND enable[n].
- R10: Changing a line's port or pin select never sets its flag by itself, even when the old and new sources differ in value.
- R11: A set flag stays set until it is cleared through R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_addr_i | input | 3 | Register address (0..6, 7 ignored) |
| wr_data_i | input | 32 | Register write data |
| pins_i | input | NUM_PORTS*PORT_PINS | Synchronised pin levels, port p at bits [16p+15:16p] |
| flags_o | output | 16 | Pending flag per line |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The bench targets the same-cycle race between a clear and a new edge. A design that lets the clear win loses an interrupt. It also re-points a line onto a pin whose level differs from the old source. A design that does not reload the stored value raises a spurious flag there. Further cases drive pins next to the selected one and inside other ports, and a routing bug would show up as a flag on the wrong line. Edges of disabled polarity and zero bits in the clear word are applied, and a fault in either would set or drop flags when it should not. Flags are also raised while their enable bit is 0, so a design that gates the flag instead of the output would miss them.

// File: rtl/exti_pkg.sv
`timescale 1ns/1ps
package exti_pkg;
    localparam int LINES        = 16;
    localparam int GROUP        = 4;
    localparam int PINSEL_W     = 2;
    localparam int PSEL_FIELD_W = 4;
    localparam int HALF         = LINES / 2;
    localparam int REG_W        = 32;
    localparam int ADDR_W       = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_PSEL_LO = 3'd0,
        A_PSEL_HI = 3'd1,
        A_PINSEL  = 3'd2,
        A_RISE    = 3'd3,
        A_FALL    = 3'd4,
        A_IEN     = 3'd5,
        A_CLR     = 3'd6
    } reg_addr_e;

    typedef enum logic {
        LN_IDLE = 1'b0,
        LN_PEND = 1'b1
    } line_state_e;
endpackage

// File: rtl/exti_cfg_regs.sv
`timescale 1ns/1ps
module exti_cfg_regs
    import exti_pkg::*;
#(
    parameter int PORT_W = 2
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic                                 wr_en_i,
    input  logic [ADDR_W-1:0]                    wr_addr_i,
    input  logic [REG_W-1:0]                     wr_data_i,
    output logic [LINES-1:0][PORT_W-1:0]         port_sel_o,
    output logic [LINES-1:0][PINSEL_W-1:0]       pin_sel_o,
    output logic [LINES-1:0]                     rise_en_o,
    output logic [LINES-1:0]                     fall_en_o,
    output logic [LINES-1:0]                     ien_o,
    output logic [LINES-1:0]                     clr_o
);
    // configuration state, all zero out of reset (R1)
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            port_sel_o <= '0;
            pin_sel_o  <= '0;
            rise_en_o  <= '0;
            fall_en_o  <= '0;
            ien_o      <= '0;
        end else if (wr_en_i) begin
            case (reg_addr_e'(wr_addr_i))
                A_PSEL_LO: begin
                    for (int i = 0; i < HALF; i++)
                        port_sel_o[i] <= wr_data_i[i*PSEL_FIELD_W +: PORT_W];
                end
                A_PSEL_HI: begin
                    for (int i = 0; i < HALF; i++)
                        port_sel_o[HALF+i] <= wr_data_i[i*PSEL_FIELD_W +: PORT_W];
                end
                A_PINSEL: pin_sel_o <= wr_data_i[LINES*PINSEL_W-1:0];
                A_RISE:   rise_en_o <= wr_data_i[LINES-1:0];
                A_FALL:   fall_en_o <= wr_data_i[LINES-1:0];
                A_IEN:    ien_o     <= wr_data_i[LINES-1:0];
                default:  ;
            endcase
        end
    end

    // write-one-to-clear strobe, valid only in the write cycle (R7)
    always_comb begin
        clr_o = '0;
        if (wr_en_i && (wr_addr_i == A_CLR))
            clr_o = wr_data_i[LINES-1:0];
    end
endmodule

// File: rtl/exti_line.sv
`timescale 1ns/1ps
module exti_line
    import exti_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_PINS = 16,
    parameter int PORT_W    = 2,
    parameter int LINE_IDX  = 0
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  logic [NUM_PORTS-1:0][PORT_PINS-1:0]   pin_grid_i,
    input  logic [PORT_W-1:0]                     port_sel_i,
    input  logic [PINSEL_W-1:0]                   pin_sel_i,
    input  logic                                  rise_en_i,
    input  logic                                  fall_en_i,
    input  logic                                  clr_i,
    output logic                                  flag_o
);
    localparam int PIN_W    = $clog2(PORT_PINS);
    localparam int GRP_BASE = (LINE_IDX / GROUP) * GROUP;
    localparam int SRC_W    = PORT_W + PINSEL_W;

    line_state_e        state_q, state_nx;
    logic [PIN_W-1:0]   pin_idx;
    logic [SRC_W-1:0]   src_now, src_q;
    logic               src_val, prev_q;
    logic               moved, hit;

    // pin is confined to the group of this line (R6)
    assign pin_idx = PIN_W'(GRP_BASE) + PIN_W'(pin_sel_i);
    assign src_val = pin_grid_i[port_sel_i][pin_idx];
    assign src_now = {port_sel_i, pin_sel_i};
    // source changed since last cycle: reload only, no edge (R10)
    assign moved   = (src_now != src_q);
    assign hit     = !moved && ((rise_en_i && !prev_q &&  src_val) ||
                                (fall_en_i &&  prev_q && !src_val));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= LN_IDLE;
            prev_q  <= 1'b0;
            src_q   <= '0;
        end else begin
            state_q <= state_nx;
            prev_q  <= src_val;
            src_q   <= src_now;
        end
    end

    // arm on edge; release on clear unless an edge lands the same cycle (R8)
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            LN_IDLE: if (hit)             state_nx = LN_PEND;
            LN_PEND: if (clr_i && !hit)   state_nx = LN_IDLE;
            default:                      state_nx = LN_IDLE;
        endcase
    end

    always_comb flag_o = (state_q == LN_PEND);
endmodule

// File: rtl/exti_router.sv
`timescale 1ns/1ps
module exti_router
    import exti_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_PINS = 16
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           wr_en_i,
    input  logic [ADDR_W-1:0]              wr_addr_i,
    input  logic [REG_W-1:0]               wr_data_i,
    input  logic [NUM_PORTS*PORT_PINS-1:0] pins_i,
    output logic [LINES-1:0]               flags_o,
    output logic                           irq_o
);
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    if (PORT_PINS < LINES || PORT_W > PSEL_FIELD_W || (1 << PORT_W) != NUM_PORTS) begin : g_bad_cfg
        $error("exti_router: unsupported port geometry");
    end

    logic [NUM_PORTS-1:0][PORT_PINS-1:0] pin_grid;
    logic [LINES-1:0][PORT_W-1:0]        port_sel;
    logic [LINES-1:0][PINSEL_W-1:0]      pin_sel;
    logic [LINES-1:0]                    rise_en, fall_en, ien_en, clr_mask;

    assign pin_grid = pins_i;

    exti_cfg_regs #(.PORT_W(PORT_W)) u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .port_sel_o (port_sel),
        .pin_sel_o  (pin_sel),
        .rise_en_o  (rise_en),
        .fall_en_o  (fall_en),
        .ien_o      (ien_en),
        .clr_o      (clr_mask)
    );

    for (genvar n = 0; n < LINES; n++) begin : g_line
        exti_line #(
            .NUM_PORTS (NUM_PORTS),
            .PORT_PINS (PORT_PINS),
            .PORT_W    (PORT_W),
            .LINE_IDX  (n)
        ) u_line (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .pin_grid_i (pin_grid),
            .port_sel_i (port_sel[n]),
            .pin_sel_i  (pin_sel[n]),
            .rise_en_i  (rise_en[n]),
            .fall_en_i  (fall_en[n]),
            .clr_i      (clr_mask[n]),
            .flag_o     (flags_o[n])
        );
    end

    // masking applies to the output only (R9)
    assign irq_o = |(flags_o & ien_en);
endmodule

// File: rtl/exti_router_chk.sv
`timescale 1ns/1ps
module exti_router_chk
    import exti_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [LINES-1:0]  clr_data_i,
    input logic [LINES-1:0]  flags_o,
    input logic              irq_o,
    input logic [LINES-1:0]  rise_en,
    input logic [LINES-1:0]  fall_en
);
    logic [LINES-1:0] clr_vec;
    assign clr_vec = (wr_en_i && wr_addr_i == A_CLR) ? clr_data_i : '0;

    a_r1_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (flags_o == '0 && !irq_o));

    a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((($past(flags_o) & ~flags_o) & ~$past(clr_vec)) == '0));

    a_r4_no_enable_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (((flags_o & ~$past(flags_o)) & ~$past(rise_en | fall_en)) == '0));

    a_r7_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_vec != '0) |=> ((flags_o & $past(clr_vec) & ~$past(rise_en | fall_en)) == '0));

    a_r9_irq_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (flags_o != '0));
endmodule

bind exti_router exti_router_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .clr_data_i (wr_data_i[15:0]),
    .flags_o    (flags_o),
    .irq_o      (irq_o),
    .rise_en    (rise_en),
    .fall_en    (fall_en)
);

// File: tb/exti_router_tb_top.sv
`timescale 1ns/1ps
module exti_router_tb_top;
    localparam int VW   = 121;
    localparam int NV   = 21;
    localparam int PINW = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [2:0]      wr_addr = '0;
    logic [31:0]     wr_data = '0;
    logic [PINW-1:0] pins = '0;
    logic [15:0]     flags;
    logic            irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    exti_router dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .pins_i    (pins),
        .flags_o   (flags),
        .irq_o     (irq)
    );

    // {req[3:0], wr, addr[2:0], data[31:0], pins[63:0], exp_flags[15:0], exp_irq}
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd2,  1'b1, 3'd3, 32'h0000_0001, 64'h0,             16'h0000, 1'b0}, // R2 rise line0
        {4'd2,  1'b0, 3'd0, 32'h0,         64'h1,             16'h0001, 1'b0}, // R2 edge pin0
        {4'd9,  1'b1, 3'd5, 32'h0000_0001, 64'h1,             16'h0001, 1'b1}, // R9 enable line0
        {4'd11, 1'b1, 3'd6, 32'h0000_0000, 64'h1,             16'h0001, 1'b1}, // R11 zero clear
        {4'd7,  1'b1, 3'd6, 32'h0000_0001, 64'h1,             16'h0000, 1'b0}, // R7 clear line0
        {4'd4,  1'b0, 3'd0, 32'h0,         64'h0,             16'h0000, 1'b0}, // R4 fall off
        {4'd3,  1'b1, 3'd4, 32'h0000_0010, 64'h0,             16'h0000, 1'b0}, // R3 fall line4
        {4'd4,  1'b0, 3'd0, 32'h0,         64'h10,            16'h0000, 1'b0}, // R4 rise off line4
        {4'd3,  1'b0, 3'd0, 32'h0,         64'h0,             16'h0010, 1'b0}, // R3 fall pin4
        {4'd6,  1'b1, 3'd2, 32'h0000_0C00, 64'h0,             16'h0010, 1'b0}, // R6 line5 sel3
        {4'd6,  1'b1, 3'd3, 32'h0000_0021, 64'h0,             16'h0010, 1'b0}, // R6 rise line5
        {4'd6,  1'b0, 3'd0, 32'h0,         64'h40,            16'h0010, 1'b0}, // R6 pin6 ignored
        {4'd6,  1'b0, 3'd0, 32'h0,         64'hC0,            16'h0030, 1'b0}, // R6 pin7 hits
        {4'd5,  1'b1, 3'd1, 32'h0000_0020, 64'hC0,            16'h0030, 1'b0}, // R5 line9 port2
        {4'd3,  1'b1, 3'd4, 32'h0000_0210, 64'hC0,            16'h0030, 1'b0}, // R3 fall line9
        {4'd5,  1'b1, 3'd3, 32'h0000_0221, 64'hC0,            16'h0030, 1'b0}, // R5 rise line9
        {4'd5,  1'b0, 3'd0, 32'h0,         64'h1C0,           16'h0030, 1'b0}, // R5 port0 pin8 ignored
        {4'd5,  1'b0, 3'd0, 32'h0,         64'h100_0000_01C0, 16'h0230, 1'b0}, // R5 port2 pin8
        {4'd7,  1'b1, 3'd6, 32'h0000_FFFF, 64'h100_0000_01C0, 16'h0000, 1'b0}, // R7 clear all
        {4'd3,  1'b0, 3'd0, 32'h0,         64'h1C0,           16'h0200, 1'b0}, // R3 both edges
        {4'd9,  1'b1, 3'd5, 32'h0000_0200, 64'h1C0,           16'h0200, 1'b1}  // R9 irq line9
    };

    task automatic check(input string req, input logic [15:0] ef, input logic ei);
        n_cmp++;
        if (flags !== ef || irq !== ei) begin
            n_bad++;
            $display("FAIL %s: flags=%h irq=%b expected flags=%h irq=%b", req, flags, irq, ef, ei);
        end
    endtask

    task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d,
                        input logic [PINW-1:0] p);
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d; pins = p;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then pin activity with no enables
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 16'h0000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 3'd0, 32'h0, 64'hFFFF);
        check("R1 after release", 16'h0000, 1'b0);
        step(1'b0, 3'd0, 32'h0, 64'h0);
        check("R1 no enables", 16'h0000, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            string tag;
            v = VEC[i];
            step(v[116], v[115:113], v[112:81], v[80:17]);
            tag = $sformatf("R%0d vec%0d", v[120:117], i);
            check(tag, v[16:1], v[0]);
        end

        // R8: edge on line0 and its clear in the same cycle
        step(1'b1, 3'd6, 32'h0000_0001, 64'h1C1);
        check("R8 set wins", 16'h0201, 1'b1);
        step(1'b1, 3'd6, 32'h0000_0201, 64'h1C1);
        check("R7 clear two", 16'h0000, 1'b0);
        // R4: pin7 falls (rise only), pin4 rises (fall only), pin0 falls (rise only)
        step(1'b0, 3'd0, 32'h0, 64'h150);
        check("R4 wrong polarity", 16'h0000, 1'b0);
        // R10: re-point line5 from pin7 (0) to pin4 (1)
        step(1'b1, 3'd2, 32'h0, 64'h150);
        check("R10 select write", 16'h0000, 1'b0);
        step(1'b0, 3'd0, 32'h0, 64'h150);
        check("R10 no false edge", 16'h0000, 1'b0);
        // R6: line5 now follows pin4
        step(1'b0, 3'd0, 32'h0, 64'h140);
        check("R6 line4 fall", 16'h0010, 1'b0);
        step(1'b0, 3'd0, 32'h0, 64'h150);
        check("R6 line5 on pin4", 16'h0030, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule